// File: doc/BRIEF.md
# I2C Slave Receive/Transmit Engine

This block is the slave side of a two-wire serial bus. It oversamples the SCL and SDA pins with the system clock and detects START and STOP conditions. It compares the first byte after a START with a programmed 7-bit address, or with the general-call address. It then either collects data bytes from the bus master or shifts data bytes out to it. It drives the open-drain lines only by pulling low: `sda_oe_o` pulls SDA low, and `scl_oe_o` holds SCL low to stretch the clock.

Received bytes leave through a one-entry valid/ready output. `rx_valid_o` is the buffer-full flag. A byte waits there until the consumer raises `rx_ready_i`, and the buffer does not accept a new byte while it is full. That back-pressure is applied on the bus: the slave answers NACK and raises the overflow flag, and it does not stall the bus. Transmit bytes enter through a one-entry valid/ready input, and `tx_ready_o` is high while that entry is empty. When the master reads, the slave keeps SCL low until a byte has been loaded and `clk_release_i` has been pulsed. Each transferred byte raises a sticky interrupt request.

Top module: `i2cs_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) sets `start_seen_o`. A STOP (SDA rises while SCL is high) clears it, and the engine then waits for the next START.
- R2: `own_addr_i[7:1]` is the slave address. `own_addr_i[0]` = 1 accepts only master writes (address byte bit 0 = 0), and `own_addr_i[0]` = 0 accepts only master reads (bit 0 = 1). An accepted address is answered with ACK, meaning SDA is pulled low during the ninth SCL pulse. Any other address gets no ACK and no interrupt, and the data bytes that follow on the bus are ignored until the next START.
- R3: When `gc_en_i` = 1, the address byte 0x00 is acknowledged, raises the interrupt and is taken as a write. When `gc_en_i` = 0, the byte 0x00 is not acknowledged.
- R4: Every byte received in a write transfer, including the accepted address byte, is placed on `rx_data_o` and sets `rx_valid_o`. A cycle with `rx_valid_o` and `rx_ready_i` both high empties the buffer.
- R5: If `rx_valid_o` or `ovf_o` is already 1 when a byte completes, the byte is not acknowledged, `rx_data_o` keeps its old value and `ovf_o` is set. `ovf_o` stays set until `ovf_clr_i` is pulsed.
- R6: `irq_o` rises after the falling edge of the ninth SCL pulse of every byte the slave takes part in, including bytes it refused. It stays high until `irq_clr_i` is pulsed.
- R7: `rw_o` holds bit 0 of the most recent accepted address byte (1 = master reads).
- R8: After an acknowledged read address, and after each byte that the master acknowledges, the slave holds SCL low. The hold lasts until a byte is loaded and `clk_release_i` has been pulsed. The slave then shifts that byte out MSB first, changing SDA only while SCL is low.
- R9: If the master answers a transmitted byte with NACK, the slave releases both lines and ignores the bus until a START. A later load or release does not stretch the clock or drive SDA.
- R10: `tx_ready_o` is 1 while the transmit entry is empty. A load happens in a cycle with `tx_valid_i` and `tx_ready_o` both high, and `tx_ready_o` drops until the byte starts shifting out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | 8 | [7:1] slave address, [0] accepted direction |
| gc_en_i | input | 1 | Accept general-call address 0x00 |
| rx_valid_o | output | 1 | Receive buffer full |
| rx_ready_i | input | 1 | Consumer takes the receive byte |
| rx_data_o | output | 8 | Received byte |
| tx_valid_i | input | 1 | Producer offers a transmit byte |
| tx_ready_o | output | 1 | Transmit entry empty |
| tx_data_i | input | 8 | Transmit byte |
| clk_release_i | input | 1 | Pulse: allow the stretched clock to resume |
| irq_o | output | 1 | Sticky interrupt request |
| irq_clr_i | input | 1 | Pulse: clear the interrupt request |
| ovf_o | output | 1 | Overflow flag |
| ovf_clr_i | input | 1 | Pulse: clear the overflow flag |
| start_seen_o | output | 1 | START seen since the last STOP |
| rw_o | output | 1 | R/W bit of the last accepted address |

## Verification
The hardest situations to reach are the ones that depend on software being slow while the bus runs on. One is a byte that arrives while the previous one is still unread. The other is a master read that has to wait on a held SCL. The bench models an open-drain bus: each line is the AND of the master's drive and the inverse of the slave's pull-down. The master task waits for SCL to actually go high, so stretching is exercised for real. Overflow is forced by leaving the receive buffer unread and sending another data byte. The bench then checks for the missing ACK, the held old data and the overflow flag.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RXBYTE,
    ST_RXACK,
    ST_TXHOLD,
    ST_TXBYTE,
    ST_TXACK
  } i2cs_state_e;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda;
  } i2cs_evt_t;
endpackage

// File: rtl/i2cs_pin_sync.sv
module i2cs_pin_sync
  import i2cs_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      scl_i,
  input  logic      sda_i,
  output i2cs_evt_t evt_o
);
  localparam int NPIN = 2;
  localparam int SH_W = (STAGES < 2) ? 2 : STAGES;

  logic [NPIN-1:0] raw;
  logic [NPIN-1:0] now_v;
  logic [NPIN-1:0] prev_v;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [SH_W-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain     <= '1;
        prev_v[g] <= 1'b1;
      end else begin
        chain     <= {chain[SH_W-2:0], raw[g]};
        prev_v[g] <= chain[SH_W-1];
      end
    end
    assign now_v[g] = chain[SH_W-1];
  end

  logic scl_s, sda_s, scl_q, sda_q;
  assign scl_s = now_v[1];
  assign sda_s = now_v[0];
  assign scl_q = prev_v[1];
  assign sda_q = prev_v[0];

  always_comb begin
    evt_o.scl_rise = scl_s & ~scl_q;
    evt_o.scl_fall = ~scl_s & scl_q;
    evt_o.start    = scl_s & scl_q & sda_q & ~sda_s;
    evt_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
    evt_o.sda      = sda_s;
  end
endmodule

// File: rtl/i2cs_tx_buf.sv
module i2cs_tx_buf
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  input  logic              rel_i,
  input  logic              take_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              go_o
);
  logic full, rel_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      rel_pend <= 1'b0;
      data_o   <= '0;
    end else if (take_i) begin
      full     <= 1'b0;
      rel_pend <= 1'b0;
    end else begin
      if (tx_valid_i && !full) begin
        full   <= 1'b1;
        data_o <= tx_data_i;
      end
      if (rel_i) rel_pend <= 1'b1;
    end
  end

  assign tx_ready_o = ~full;
  assign go_o       = full & rel_pend;

  // R10: a held byte is never replaced by a later offer
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take_i) |=> (full && $stable(data_o)));
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  i2cs_evt_t         evt_i,
  input  logic [BYTE_W-1:0] own_addr_i,
  input  logic              gc_en_i,
  input  logic              rx_ready_i,
  input  logic              irq_clr_i,
  input  logic              ovf_clr_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              tx_go_i,
  output logic              tx_take_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              sda_oe_o,
  output logic              scl_oe_o,
  output logic              irq_o,
  output logic              ovf_o,
  output logic              start_seen_o,
  output logic              rw_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  i2cs_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              is_addr, ack_q, ackph, mack;
  logic [BYTE_W-1:0] byte_next;
  logic              addr_hit, gc_hit, take_byte, bus_evt;

  assign byte_next = {shreg[BYTE_W-2:0], evt_i.sda};
  assign addr_hit  = (byte_next[BYTE_W-1:1] == own_addr_i[BYTE_W-1:1]) &&
                     (byte_next[0] != own_addr_i[0]);
  assign gc_hit    = gc_en_i && (byte_next == '0);
  assign bus_evt   = evt_i.start | evt_i.stop;
  assign take_byte = (state == ST_RXBYTE) && evt_i.scl_rise && (cnt == LAST_BIT) &&
                     !bus_evt && (!is_addr || addr_hit || gc_hit);
  assign tx_take_o = (state == ST_TXHOLD) && tx_go_i && !bus_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      shreg        <= '0;
      is_addr      <= 1'b0;
      ack_q        <= 1'b0;
      ackph        <= 1'b0;
      mack         <= 1'b0;
      rx_valid_o   <= 1'b0;
      rx_data_o    <= '0;
      irq_o        <= 1'b0;
      ovf_o        <= 1'b0;
      start_seen_o <= 1'b0;
      rw_o         <= 1'b0;
    end else begin
      if (rx_ready_i && rx_valid_o) rx_valid_o <= 1'b0;
      if (irq_clr_i) irq_o <= 1'b0;
      if (ovf_clr_i) ovf_o <= 1'b0;

      if (evt_i.stop) begin
        start_seen_o <= 1'b0;
        state        <= ST_IDLE;
      end else if (evt_i.start) begin
        start_seen_o <= 1'b1;
        state        <= ST_RXBYTE;
        is_addr      <= 1'b1;
        cnt          <= '0;
      end else begin
        unique case (state)
          ST_RXBYTE: if (evt_i.scl_rise) begin
            shreg <= byte_next;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              if (take_byte) begin
                if (rx_valid_o || ovf_o) begin
                  ovf_o <= 1'b1;
                  ack_q <= 1'b0;
                end else begin
                  rx_data_o  <= byte_next;
                  rx_valid_o <= 1'b1;
                  ack_q      <= 1'b1;
                end
                if (is_addr) rw_o <= byte_next[0];
                ackph <= 1'b0;
                state <= ST_RXACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_RXACK: if (evt_i.scl_fall) begin
            if (!ackph) begin
              ackph <= 1'b1;
            end else begin
              irq_o <= 1'b1;
              ackph <= 1'b0;
              if (!ack_q)              state <= ST_IDLE;
              else if (is_addr && rw_o) state <= ST_TXHOLD;
              else begin
                state   <= ST_RXBYTE;
                is_addr <= 1'b0;
                cnt     <= '0;
              end
            end
          end
          ST_TXHOLD: if (tx_take_o) begin
            shreg <= tx_byte_i;
            cnt   <= '0;
            state <= ST_TXBYTE;
          end
          ST_TXBYTE: if (evt_i.scl_fall) begin
            cnt   <= cnt + 1'b1;
            shreg <= {shreg[BYTE_W-2:0], 1'b0};
            if (cnt == LAST_BIT) begin
              mack  <= 1'b0;
              state <= ST_TXACK;
            end
          end
          ST_TXACK: begin
            if (evt_i.scl_rise) mack <= ~evt_i.sda;
            if (evt_i.scl_fall) begin
              irq_o <= 1'b1;
              state <= mack ? ST_TXHOLD : ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o = ((state == ST_RXACK) && ackph && ack_q) ||
                    ((state == ST_TXBYTE) && !shreg[BYTE_W-1]);
  assign scl_oe_o = (state == ST_TXHOLD);

  p_start_sets_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.start && !evt_i.stop) |=> start_seen_o);
  p_stop_clears_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.stop |=> !start_seen_o);
  p_buf_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));
  p_no_overflow_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_byte && (rx_valid_o || ovf_o)) |=> (!ack_q && ovf_o));
  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o);
  p_stretch_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe_o && !tx_go_i && !bus_evt) |=> scl_oe_o);
endmodule

// File: rtl/i2cs_slave.sv
module i2cs_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [BYTE_W-1:0] own_addr_i,
  input  logic              gc_en_i,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [BYTE_W-1:0] rx_data_o,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              clk_release_i,
  output logic              irq_o,
  input  logic              irq_clr_i,
  output logic              ovf_o,
  input  logic              ovf_clr_i,
  output logic              start_seen_o,
  output logic              rw_o
);
  i2cs_evt_t         evt;
  logic [BYTE_W-1:0] tx_byte;
  logic              tx_go, tx_take;

  i2cs_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .evt_o(evt)
  );

  i2cs_tx_buf u_txb (
    .clk(clk), .rst_n(rst_n), .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
    .tx_ready_o(tx_ready_o), .rel_i(clk_release_i), .take_i(tx_take),
    .data_o(tx_byte), .go_o(tx_go)
  );

  i2cs_engine u_eng (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .own_addr_i(own_addr_i),
    .gc_en_i(gc_en_i), .rx_ready_i(rx_ready_i), .irq_clr_i(irq_clr_i),
    .ovf_clr_i(ovf_clr_i), .tx_byte_i(tx_byte), .tx_go_i(tx_go),
    .tx_take_o(tx_take), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
    .sda_oe_o(sda_oe_o), .scl_oe_o(scl_oe_o), .irq_o(irq_o), .ovf_o(ovf_o),
    .start_seen_o(start_seen_o), .rw_o(rw_o)
  );
endmodule

// File: tb/i2cs_slave_tb.sv
module i2cs_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe;
  logic [7:0] own_addr = 8'h5B;
  logic gc_en = 1'b0;
  logic rx_valid, rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic tx_valid = 1'b0, tx_ready;
  logic [7:0] tx_data = 8'h00;
  logic rel = 1'b0;
  logic irq, irq_clr = 1'b0, ovf, ovf_clr = 1'b0, start_seen, rw;
  logic scl_line, sda_line;
  int vectors = 0;
  int miscompares = 0;
  logic ack;
  logic [7:0] rb;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cs_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(own_addr), .gc_en_i(gc_en),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data),
    .clk_release_i(rel), .irq_o(irq), .irq_clr_i(irq_clr), .ovf_o(ovf),
    .ovf_clr_i(ovf_clr), .start_seen_o(start_seen), .rw_o(rw)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; idle(HALF);
    sda_m = 1'b0; idle(HALF);
    scl_m = 1'b0; idle(HALF);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; sda_m = 1'b0; idle(HALF);
    scl_m = 1'b1; idle(HALF);
    sda_m = 1'b1; idle(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; idle(HALF/2);
      scl_m = 1'b1; idle(HALF);
      scl_m = 1'b0; idle(HALF/2);
    end
    sda_m = 1'b1; idle(HALF/2);
    scl_m = 1'b1; idle(HALF/2);
    a = ~sda_line;
    idle(HALF/2);
    scl_m = 1'b0; idle(HALF);
  endtask

  task automatic read_byte(output logic [7:0] b, input logic master_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; idle(HALF/2);
      scl_m = 1'b1;
      while (!scl_line) idle(1);
      idle(HALF/2);
      b[i] = sda_line;
      idle(HALF/2);
      scl_m = 1'b0; idle(HALF/2);
    end
    sda_m = ~master_ack; idle(HALF/2);
    scl_m = 1'b1; idle(HALF);
    scl_m = 1'b0; idle(HALF/2);
    sda_m = 1'b1; idle(HALF/2);
  endtask

  task automatic pulse_irq_clr(); irq_clr = 1'b1; idle(1); irq_clr = 1'b0; endtask
  task automatic pulse_ovf_clr(); ovf_clr = 1'b1; idle(1); ovf_clr = 1'b0; endtask
  task automatic pop_rx(); rx_ready = 1'b1; idle(1); rx_ready = 1'b0; endtask
  task automatic pulse_rel(); rel = 1'b1; idle(1); rel = 1'b0; endtask
  task automatic load_tx(input logic [7:0] b);
    tx_data = b; tx_valid = 1'b1; idle(1); tx_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(3);
    // Reset state
    chk("R6 reset irq", irq, 0);
    chk("R4 reset rx_valid", rx_valid, 0);
    chk("R5 reset ovf", ovf, 0);
    chk("R1 reset start_seen", start_seen, 0);
    chk("R8 reset line drive", {scl_oe, sda_oe}, 0);
    chk("R10 reset tx_ready", tx_ready, 1);

    // Write transfer to own address 0x2D (own_addr 0x5B, accepts writes)
    bus_start();
    chk("R1 start flag", start_seen, 1);
    send_byte(8'h5A, ack);
    chk("R2 address ack", ack, 1);
    chk("R6 irq after address", irq, 1);
    chk("R4 address in buffer", {rx_valid, rx_data}, {1'b1, 8'h5A});
    chk("R7 rw write", rw, 0);
    pulse_irq_clr(); pop_rx();
    chk("R4 buffer emptied", rx_valid, 0);
    send_byte(8'hC3, ack);
    chk("R4 data ack", ack, 1);
    chk("R4 data byte", {rx_valid, rx_data}, {1'b1, 8'hC3});
    pulse_irq_clr();
    // Buffer left full: next byte overflows
    send_byte(8'h11, ack);
    chk("R5 nack when full", ack, 0);
    chk("R5 overflow flag", ovf, 1);
    chk("R5 old data kept", rx_data, 8'hC3);
    chk("R6 irq on refused byte", irq, 1);
    bus_stop();
    chk("R1 stop clears flag", start_seen, 0);
    pulse_irq_clr(); pulse_ovf_clr(); pop_rx();
    chk("R5 overflow cleared", ovf, 0);

    // Wrong address, then data is ignored
    bus_start();
    send_byte(8'h40, ack);
    chk("R2 mismatch nack", ack, 0);
    chk("R2 mismatch no irq", irq, 0);
    send_byte(8'h5A, ack);
    chk("R2 ignored until start", {ack, rx_valid, irq}, 0);
    bus_stop();

    // General call
    bus_start();
    send_byte(8'h00, ack);
    chk("R3 general call disabled", {ack, irq}, 0);
    bus_stop();
    gc_en = 1'b1;
    bus_start();
    send_byte(8'h00, ack);
    chk("R3 general call ack", {ack, irq, rx_valid, rx_data}, {3'b111, 8'h00});
    bus_stop();
    pulse_irq_clr(); pop_rx(); gc_en = 1'b0;

    // Transmit mode: accept reads only
    own_addr = 8'h5A;
    bus_start();
    send_byte(8'h5A, ack);
    chk("R2 direction mismatch nack", ack, 0);
    bus_stop();

    bus_start();
    send_byte(8'h5B, ack);
    chk("R2 read address ack", ack, 1);
    chk("R7 rw read", rw, 1);
    pulse_irq_clr(); pop_rx();
    idle(20);
    chk("R8 clock stretched", {scl_oe, scl_line}, 2'b10);
    chk("R10 tx ready empty", tx_ready, 1);
    load_tx(8'hA5);
    chk("R10 tx ready after load", tx_ready, 0);
    idle(10);
    chk("R8 held until release", scl_oe, 1);
    pulse_rel();
    read_byte(rb, 1'b1);
    chk("R8 first byte msb first", rb, 8'hA5);
    chk("R6 irq after tx byte", irq, 1);
    pulse_irq_clr();
    idle(10);
    chk("R8 stretched after master ack", scl_oe, 1);
    load_tx(8'h3C); pulse_rel();
    read_byte(rb, 1'b0);
    chk("R8 second byte", rb, 8'h3C);
    idle(10);
    chk("R9 released after master nack", {scl_oe, sda_oe}, 0);
    load_tx(8'h77); pulse_rel();
    idle(20);
    chk("R9 no drive until start", {scl_oe, sda_oe}, 0);
    bus_stop();
    chk("R1 stop after read", start_seen, 0);

    finish_run();
  end
endmodule